// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings switchable power domains up and down in a safe order, one request at a time. A request names a domain and a target state, on or off. To switch a domain off, the block first reads that domain's bus QoS settings into a local shadow store. It then isolates the domain's bus port through an idle request and acknowledge handshake. Only after that does it open the power switch. Switching a domain on runs the mirror order: close the switch, release the idle request, then write the saved QoS values back.

Each domain has its own capability mask. Any domain may lack a power switch, a power status bit, an idle handshake, QoS registers or transition counters, and the sequence skips the steps it cannot perform. After reset the block programs the power-down and power-up transition counts of the domains that have counters, over the same register master port it uses for QoS traffic. Every handshake wait is bounded by a timeout measured in microseconds. The timeout is converted to clock cycles through a cycles-per-microsecond parameter.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset, all outputs show every domain on, with no idle request and no clock enable, and `ready_o` is low. The block then issues register writes of `TRANS_CNT` for each domain d that has a counter: first the down count at `CNT_BASE + d*CNT_STRIDE`, then the up count at that address plus 4. Domains are handled in ascending order, and `ready_o` rises after the last write.
- R2: A power-off request reads the domain's `NUM_QOS` QoS registers at `QOS_BASE + d*QOS_STRIDE + 8 + 4*k`, for k ascending. It then raises `idle_req_o[d]` and waits for the acknowledge, then for the idle status. Only then does it set `pwr_off_o[d]`, and it finally waits for the domain to report off.
- R3: A power-on request clears `pwr_off_o[d]` and waits for the domain to report on. It then drops `idle_req_o[d]` and waits for acknowledge and idle status to clear. Finally it writes the saved QoS values back to the same addresses in ascending order.
- R4: `pwr_off_o[d]` = 1 commands off and 0 commands on. `pwr_sts_i[d]` = 1 reports off and 0 reports on.
- R5: A domain without a status bit is judged on when its idle status is 0. A domain without an idle handshake never raises `idle_req_o`. A domain without a power switch never changes `pwr_off_o`. A domain without QoS registers causes no register traffic during its sequence.
- R6: If any handshake wait exceeds `CYC_PER_US*TMO_US` cycles, the sequence ends with `err_o` = 1 and takes no further steps.
- R7: A request for the state the domain already has completes within three cycles, with no register traffic and no clock enable.
- R8: With `LAYOUT` = 1 (the default), the acknowledge bit of domain d is `ack_word_i[d+NUM_DOM]` and its idle bit is `idle_word_i[d]`. With `LAYOUT` = 0, both bits are at position d. With `LAYOUT` = 2, the acknowledge bit is at d and the idle bit is at d+NUM_DOM.
- R9: `done_o` is a one-cycle pulse at the end of every accepted request, and `err_o` is valid only alongside it.
- R10: `clk_en_o[d]` is high from acceptance until completion of a sequence on domain d, and at most one bit is high at any time.
- R11: `ready_o` is low while a sequence or the reset programming runs, and requests presented then are ignored.
- R12: The register master holds `bus_req_o`, `bus_we_o` and `bus_addr_o` stable until `bus_ack_i` is high. Read data is taken in the cycle of the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe, taken when ready_o is high |
| req_dom_i | input | DOM_W | Domain index of the request |
| req_on_i | input | 1 | 1 = power on, 0 = power off |
| ready_o | output | 1 | Block idle and able to take a request |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with done_o |
| idle_req_o | output | NUM_DOM | Per-domain bus idle request |
| pwr_off_o | output | NUM_DOM | Per-domain power switch command, 1 = off |
| clk_en_o | output | NUM_DOM | Per-domain bus clock enable during a sequence |
| ack_word_i | input | 2*NUM_DOM | Idle acknowledge word |
| idle_word_i | input | 2*NUM_DOM | Idle status word |
| pwr_sts_i | input | NUM_DOM | Per-domain power status, 1 = off |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ack_i |
| bus_ack_i | input | 1 | Access complete |

## Verification
The hardest case to reach from the ports is a power-on that must restore values differing from what the QoS registers hold at that moment. The bench's register responder changes its read pattern between the power-off and the power-on, so a restore that re-reads registers, or writes anything other than the shadowed values, is exposed. The timeout path is reached by a domain model that places the acknowledge on the bit position of the wrong layout. This stalls the handshake and also proves which bit the block actually watches.

// File: rtl/pwr_dom_seq_pkg.sv
package pwr_dom_seq_pkg;

  typedef enum logic [3:0] {
    S_INIT,
    S_IDLE,
    S_SAVE,
    S_IREQ,
    S_WACK,
    S_WIDLE,
    S_PSW,
    S_WPWR,
    S_FETCH,
    S_RWR,
    S_FIN
  } seq_state_t;

  localparam int QOS_FIRST_OFS = 8;
  localparam int QOS_STEP      = 4;
  localparam int CNT_UP_OFS    = 4;

endpackage

// File: rtl/pwr_dom_bitmap.sv
module pwr_dom_bitmap #(
  parameter int NUM_DOM = 4,
  parameter int LAYOUT  = 1
) (
  input  logic [2*NUM_DOM-1:0] ack_word_i,
  input  logic [2*NUM_DOM-1:0] idle_word_i,
  output logic [NUM_DOM-1:0]   ack_o,
  output logic [NUM_DOM-1:0]   idle_o
);

  logic unused_bits;
  assign unused_bits = ^{ack_word_i, idle_word_i};

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_map
    if (LAYOUT == 0) begin : g_same
      assign ack_o[d]  = ack_word_i[d];
      assign idle_o[d] = idle_word_i[d];
    end else if (LAYOUT == 1) begin : g_ack_high
      assign ack_o[d]  = ack_word_i[d+NUM_DOM];
      assign idle_o[d] = idle_word_i[d];
    end else begin : g_idle_high
      assign ack_o[d]  = ack_word_i[d];
      assign idle_o[d] = idle_word_i[d+NUM_DOM];
    end
  end

endmodule

// File: rtl/pwr_dom_timer.sv
module pwr_dom_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i || !run_i) cnt_q <= '0;
    else if (cnt_q < CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && !clr_i && (cnt_q >= CW'(LIMIT - 1));

  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (rst)
    run_i && !clr_i |-> cnt_q < CW'(LIMIT));

endmodule

// File: rtl/pwr_dom_shadow.sv
module pwr_dom_shadow #(
  parameter int DEPTH  = 20,
  parameter int DATA_W = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_dom_seq_pkg::*;
#(
  parameter int               NUM_DOM    = 4,
  parameter int               NUM_QOS    = 5,
  parameter int               ADDR_W     = 16,
  parameter int               DATA_W     = 32,
  parameter int               CYC_PER_US = 100,
  parameter int               TMO_US     = 10000,
  parameter int               LAYOUT     = 1,
  parameter int               TRANS_CNT  = 24,
  parameter int               CNT_BASE   = 'h34,
  parameter int               CNT_STRIDE = 8,
  parameter int               QOS_BASE   = 'h1000,
  parameter int               QOS_STRIDE = 'h80,
  parameter logic [NUM_DOM-1:0] HAS_PWR  = 4'b1011,
  parameter logic [NUM_DOM-1:0] HAS_STAT = 4'b1011,
  parameter logic [NUM_DOM-1:0] HAS_REQ  = 4'b1101,
  parameter logic [NUM_DOM-1:0] HAS_QOS  = 4'b1101,
  parameter logic [NUM_DOM-1:0] HAS_CNT  = 4'b0011,
  localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid_i,
  input  logic [DOM_W-1:0]     req_dom_i,
  input  logic                 req_on_i,
  output logic                 ready_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [NUM_DOM-1:0]   idle_req_o,
  output logic [NUM_DOM-1:0]   pwr_off_o,
  output logic [NUM_DOM-1:0]   clk_en_o,
  input  logic [2*NUM_DOM-1:0] ack_word_i,
  input  logic [2*NUM_DOM-1:0] idle_word_i,
  input  logic [NUM_DOM-1:0]   pwr_sts_i,
  output logic                 bus_req_o,
  output logic                 bus_we_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic [DATA_W-1:0]    bus_wdata_o,
  input  logic [DATA_W-1:0]    bus_rdata_i,
  input  logic                 bus_ack_i
);

  localparam int TMO_CYC  = CYC_PER_US * TMO_US;
  localparam int SH_DEPTH = NUM_DOM * NUM_QOS;
  localparam int SH_AW    = (SH_DEPTH > 1) ? $clog2(SH_DEPTH) : 1;
  localparam int CI_N     = 2 * NUM_DOM;
  localparam int CI_W     = $clog2(CI_N);
  localparam int QK_W     = (NUM_QOS > 1) ? $clog2(NUM_QOS) : 1;

  seq_state_t state_q, prev_q;

  logic [CI_W-1:0]    ci_q;
  logic [QK_W-1:0]    qk_q;
  logic [DOM_W-1:0]   dom_q;
  logic               on_q;
  logic               fail_q;
  logic [NUM_DOM-1:0] idle_req_q, pwr_off_q, clk_en_q;
  logic               done_q, err_q;
  logic               bus_req_q, bus_we_q;
  logic [ADDR_W-1:0]  bus_addr_q;
  logic [DATA_W-1:0]  bus_wdata_q;

  logic [NUM_DOM-1:0] ack_v, idle_v, is_on_v;
  logic               tmo;
  logic               tmr_run;
  logic               sh_we;
  logic [SH_AW-1:0]   sh_addr;
  logic [DATA_W-1:0]  sh_rdata;
  logic [DOM_W-1:0]   ci_dom;
  logic [ADDR_W-1:0]  cnt_addr, qos_addr;
  logic               bus_done;
  logic               unused_sts;

  pwr_dom_bitmap #(.NUM_DOM(NUM_DOM), .LAYOUT(LAYOUT)) u_map (
    .ack_word_i (ack_word_i),
    .idle_word_i(idle_word_i),
    .ack_o      (ack_v),
    .idle_o     (idle_v)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_on
    if (HAS_STAT[d]) begin : g_sts
      assign is_on_v[d] = ~pwr_sts_i[d];
    end else begin : g_idl
      assign is_on_v[d] = ~idle_v[d];
    end
  end
  assign unused_sts = ^pwr_sts_i;

  assign tmr_run = (state_q == S_WACK) || (state_q == S_WIDLE) || (state_q == S_WPWR);

  pwr_dom_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (state_q != prev_q),
    .run_i    (tmr_run),
    .expired_o(tmo)
  );

  assign sh_addr = SH_AW'(int'(dom_q) * NUM_QOS + int'(qk_q));
  assign sh_we   = (state_q == S_SAVE) && bus_req_q && bus_ack_i;

  pwr_dom_shadow #(.DEPTH(SH_DEPTH), .DATA_W(DATA_W)) u_shadow (
    .clk    (clk),
    .we_i   (sh_we),
    .waddr_i(sh_addr),
    .wdata_i(bus_rdata_i),
    .raddr_i(sh_addr),
    .rdata_o(sh_rdata)
  );

  assign ci_dom   = DOM_W'(ci_q >> 1);
  assign cnt_addr = ADDR_W'(CNT_BASE + int'(ci_dom) * CNT_STRIDE + (ci_q[0] ? CNT_UP_OFS : 0));
  assign qos_addr = ADDR_W'(QOS_BASE + int'(dom_q) * QOS_STRIDE + QOS_FIRST_OFS + QOS_STEP * int'(qk_q));
  assign bus_done = bus_req_q && bus_ack_i;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= S_INIT;
    else     prev_q <= state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_INIT;
      ci_q        <= '0;
      qk_q        <= '0;
      dom_q       <= '0;
      on_q        <= 1'b0;
      fail_q      <= 1'b0;
      idle_req_q  <= '0;
      pwr_off_q   <= '0;
      clk_en_q    <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      bus_req_q   <= 1'b0;
      bus_we_q    <= 1'b0;
      bus_addr_q  <= '0;
      bus_wdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_INIT: begin
          if (!HAS_CNT[ci_dom] || bus_done) begin
            bus_req_q <= 1'b0;
            if (int'(ci_q) == CI_N - 1) state_q <= S_IDLE;
            else ci_q <= ci_q + 1'b1;
          end else if (!bus_req_q) begin
            bus_req_q   <= 1'b1;
            bus_we_q    <= 1'b1;
            bus_addr_q  <= cnt_addr;
            bus_wdata_q <= DATA_W'(TRANS_CNT);
          end
        end
        S_IDLE: begin
          if (req_valid_i) begin
            dom_q  <= req_dom_i;
            on_q   <= req_on_i;
            fail_q <= 1'b0;
            qk_q   <= '0;
            if (is_on_v[req_dom_i] == req_on_i) begin
              state_q <= S_FIN;
            end else begin
              clk_en_q[req_dom_i] <= 1'b1;
              state_q <= req_on_i ? S_PSW : S_SAVE;
            end
          end
        end
        S_SAVE: begin
          if (!HAS_QOS[dom_q]) begin
            state_q <= S_IREQ;
          end else if (bus_done) begin
            bus_req_q <= 1'b0;
            if (int'(qk_q) == NUM_QOS - 1) begin
              qk_q    <= '0;
              state_q <= S_IREQ;
            end else begin
              qk_q <= qk_q + 1'b1;
            end
          end else if (!bus_req_q) begin
            bus_req_q  <= 1'b1;
            bus_we_q   <= 1'b0;
            bus_addr_q <= qos_addr;
          end
        end
        S_IREQ: begin
          if (!HAS_REQ[dom_q]) begin
            state_q <= on_q ? S_FETCH : S_PSW;
          end else begin
            idle_req_q[dom_q] <= ~on_q;
            state_q <= S_WACK;
          end
        end
        S_WACK: begin
          if (ack_v[dom_q] == ~on_q) state_q <= S_WIDLE;
          else if (tmo) begin
            fail_q  <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_WIDLE: begin
          if (idle_v[dom_q] == ~on_q) state_q <= on_q ? S_FETCH : S_PSW;
          else if (tmo) begin
            fail_q  <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_PSW: begin
          if (!HAS_PWR[dom_q]) begin
            state_q <= on_q ? S_IREQ : S_FIN;
          end else begin
            pwr_off_q[dom_q] <= ~on_q;
            state_q <= S_WPWR;
          end
        end
        S_WPWR: begin
          if (is_on_v[dom_q] == on_q) state_q <= on_q ? S_IREQ : S_FIN;
          else if (tmo) begin
            fail_q  <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_FETCH: begin
          state_q <= HAS_QOS[dom_q] ? S_RWR : S_FIN;
        end
        S_RWR: begin
          if (bus_done) begin
            bus_req_q <= 1'b0;
            if (int'(qk_q) == NUM_QOS - 1) begin
              qk_q    <= '0;
              state_q <= S_FIN;
            end else begin
              qk_q    <= qk_q + 1'b1;
              state_q <= S_FETCH;
            end
          end else if (!bus_req_q) begin
            bus_req_q   <= 1'b1;
            bus_we_q    <= 1'b1;
            bus_addr_q  <= qos_addr;
            bus_wdata_q <= sh_rdata;
          end
        end
        S_FIN: begin
          clk_en_q <= '0;
          done_q   <= 1'b1;
          err_q    <= fail_q;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign idle_req_o  = idle_req_q;
  assign pwr_off_o   = pwr_off_q;
  assign clk_en_o    = clk_en_q;
  assign bus_req_o   = bus_req_q;
  assign bus_we_o    = bus_we_q;
  assign bus_addr_o  = bus_addr_q;
  assign bus_wdata_o = bus_wdata_q;

  assert_onehot_clken_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clk_en_q));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
    (|clk_en_q) |-> !ready_o);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    err_q |-> done_q);

  assert_bus_hold_R12: assert property (@(posedge clk) disable iff (rst)
    bus_req_q && !bus_ack_i |=> bus_req_q && $stable(bus_addr_q) && $stable(bus_we_q));

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_order
    if (HAS_REQ[d] && HAS_PWR[d]) begin : g_chk
      assert_off_isolated_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_off_q[d]) |-> idle_req_q[d]);
      assert_on_before_release_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(idle_req_q[d]) |-> !pwr_off_q[d]);
    end
  end

endmodule

// File: tb/pwr_dom_seq_bench.sv
`timescale 1ns/1ps
module pwr_dom_seq_bench;

  localparam int N      = 4;
  localparam int TMO    = 40;
  localparam int QBASE  = 'h1000;
  localparam int QSTR   = 'h80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [1:0]    req_dom   = '0;
  logic          req_on    = 1'b0;
  logic          ready_o, done_o, err_o;
  logic [N-1:0]  idle_req_o, pwr_off_o, clk_en_o;
  logic [2*N-1:0] ack_word = '0, idle_word = '0;
  logic [N-1:0]  pwr_sts = '0;
  logic          bus_req_o, bus_we_o;
  logic [15:0]   bus_addr_o;
  logic [31:0]   bus_wdata_o;
  logic [31:0]   bus_rdata = '0;
  logic          bus_ack = 1'b0;

  pwr_dom_seq #(.CYC_PER_US(1), .TMO_US(TMO)) u_pwr_dom_seq (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_dom_i(req_dom), .req_on_i(req_on),
    .ready_o(ready_o), .done_o(done_o), .err_o(err_o),
    .idle_req_o(idle_req_o), .pwr_off_o(pwr_off_o), .clk_en_o(clk_en_o),
    .ack_word_i(ack_word), .idle_word_i(idle_word), .pwr_sts_i(pwr_sts),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // transaction log
  logic        t_we   [64];
  logic [15:0] t_addr [64];
  logic [31:0] t_data [64];
  int          t_cyc  [64];
  int          t_n = 0;
  logic [7:0]  epoch = 8'h00;
  bit          wrong_ack = 1'b0;

  // event log
  int ireq_rise [N], ireq_fall [N], pwr_rise [N], pwr_fall [N];
  logic [N-1:0] clk_seen = '0, ireq_seen = '0;
  int done_cnt = 0;
  logic [N-1:0] prev_ireq = '0, prev_pwr = '0;

  function automatic logic [31:0] reg_val(input logic [15:0] a, input logic [7:0] e);
    return 32'hC0DE_0000 ^ {16'h0, a} ^ {16'h0, e, 8'h00};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // register responder
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req_o && !bus_ack) begin
        bus_ack = 1'b1;
        if (!bus_we_o) bus_rdata = reg_val(bus_addr_o, epoch);
        if (t_n < 64) begin
          t_we[t_n]   = bus_we_o;
          t_addr[t_n] = bus_addr_o;
          t_data[t_n] = bus_we_o ? bus_wdata_o : bus_rdata;
          t_cyc[t_n]  = cyc;
          t_n++;
        end
      end else begin
        bus_ack = 1'b0;
      end
    end
  end

  // domain model and monitor
  initial begin
    logic [N-1:0] ack_int, idle_int;
    ack_int = '0;
    idle_int = '0;
    forever begin
      @(negedge clk);
      idle_int = ack_int;
      ack_int  = idle_req_o;
      pwr_sts  = pwr_off_o;
      ack_word  = wrong_ack ? {{N{1'b0}}, ack_int} : {ack_int, {N{1'b0}}};
      idle_word = {{N{1'b0}}, idle_int};
      if (!rst) begin
        for (int d = 0; d < N; d++) begin
          if (idle_req_o[d] && !prev_ireq[d]) ireq_rise[d] = cyc;
          if (!idle_req_o[d] && prev_ireq[d]) ireq_fall[d] = cyc;
          if (pwr_off_o[d] && !prev_pwr[d]) pwr_rise[d] = cyc;
          if (!pwr_off_o[d] && prev_pwr[d]) pwr_fall[d] = cyc;
        end
        clk_seen  = clk_seen | clk_en_o;
        ireq_seen = ireq_seen | idle_req_o;
        if (done_o) done_cnt++;
      end
      prev_ireq = idle_req_o;
      prev_pwr  = pwr_off_o;
    end
  end

  task automatic issue(input int d, input bit on);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    clk_seen  = '0;
    ireq_seen = '0;
    req_dom   = 2'(d);
    req_on    = on;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string rq, input int limit, output bit err, output int took);
    int c0;
    c0 = cyc;
    err = 1'b0;
    while (!done_o && (cyc - c0) < limit) @(negedge clk);
    took = cyc - c0;
    chk(done_o, rq, "done seen", done_o, 1);
    err = err_o;
    @(negedge clk);
    chk(!done_o && !err_o, "R9", "done single pulse", done_o, 0);
  endtask

  task automatic t_reset;
    chk(pwr_off_o == '0 && idle_req_o == '0 && clk_en_o == '0, "R1", "reset outputs",
        {pwr_off_o, idle_req_o, clk_en_o}, 0);
    chk(!ready_o, "R1", "ready low during init", ready_o, 0);
    while (!ready_o) @(negedge clk);
    chk(t_n == 4, "R1", "counter write count", t_n, 4);
    for (int i = 0; i < 4; i++) begin
      chk(t_we[i] && t_addr[i] == 16'(32'h34 + 4 * i) && t_data[i] == 32'd24, "R1",
          "counter write", {t_addr[i], t_data[i]}, {16'(32'h34 + 4 * i), 32'd24});
    end
  endtask

  task automatic t_off_d0;
    bit e; int took, n0, dc0;
    n0 = t_n;
    dc0 = done_cnt;
    issue(0, 1'b0);
    repeat (2) @(negedge clk);
    chk(!ready_o, "R11", "ready low while busy", ready_o, 0);
    req_dom = 2'd3; req_on = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R2", 200, e, took);
    chk(!e, "R6", "no error on d0 off", e, 0);
    chk(t_n - n0 == 5, "R2", "qos read count", t_n - n0, 5);
    for (int k = 0; k < 5; k++) begin
      chk(!t_we[n0+k] && t_addr[n0+k] == 16'(QBASE + 8 + 4 * k), "R2", "qos read addr",
          t_addr[n0+k], 16'(QBASE + 8 + 4 * k));
    end
    chk(ireq_rise[0] > t_cyc[n0+4], "R2", "idle req after save", ireq_rise[0], t_cyc[n0+4]);
    chk(pwr_rise[0] > ireq_rise[0] + 1, "R2", "switch after handshake", pwr_rise[0], ireq_rise[0]);
    chk(pwr_off_o[0] && pwr_sts[0], "R4", "d0 off polarity", {pwr_off_o[0], pwr_sts[0]}, 2'b11);
    chk(clk_seen == 4'b0001 && clk_en_o == '0, "R10", "clock enable window", clk_seen, 1);
    repeat (4) @(negedge clk);
    chk(pwr_off_o[3] == 1'b0 && done_cnt - dc0 == 1, "R11", "busy request ignored",
        {pwr_off_o[3], 8'(done_cnt - dc0)}, 1);
  endtask

  task automatic t_on_d0;
    bit e; int took, n0;
    epoch = 8'h5A;
    n0 = t_n;
    issue(0, 1'b1);
    wait_done("R3", 200, e, took);
    chk(!e && pwr_off_o[0] == 1'b0 && idle_req_o[0] == 1'b0, "R3", "d0 back on",
        {e, pwr_off_o[0], idle_req_o[0]}, 0);
    chk(t_n - n0 == 5, "R3", "restore write count", t_n - n0, 5);
    for (int k = 0; k < 5; k++) begin
      chk(t_we[n0+k] && t_addr[n0+k] == 16'(QBASE + 8 + 4 * k) &&
          t_data[n0+k] == reg_val(16'(QBASE + 8 + 4 * k), 8'h00), "R3", "restored value",
          t_data[n0+k], reg_val(16'(QBASE + 8 + 4 * k), 8'h00));
    end
    chk(pwr_fall[0] < ireq_fall[0] && ireq_fall[0] < t_cyc[n0], "R3", "on order",
        ireq_fall[0], pwr_fall[0]);
  endtask

  task automatic t_already;
    bit e; int took, n0;
    n0 = t_n;
    issue(0, 1'b1);
    wait_done("R7", 10, e, took);
    chk(took <= 3 && !e, "R7", "fast completion", took, 3);
    chk(t_n == n0 && clk_seen == '0, "R7", "no activity", {8'(t_n - n0), clk_seen}, 0);
  endtask

  task automatic t_no_handshake;
    bit e; int took, n0;
    n0 = t_n;
    issue(1, 1'b0);
    wait_done("R5", 100, e, took);
    chk(!e && pwr_off_o[1] && ireq_seen[1] == 1'b0, "R5", "d1 off without handshake",
        {e, pwr_off_o[1], ireq_seen[1]}, 3'b010);
    chk(t_n == n0, "R5", "d1 no register traffic", t_n - n0, 0);
  endtask

  task automatic t_idle_only;
    bit e; int took, n0;
    n0 = t_n;
    issue(2, 1'b0);
    wait_done("R5", 200, e, took);
    chk(!e && idle_req_o[2] && !pwr_off_o[2], "R5", "d2 idle-only off",
        {e, idle_req_o[2], pwr_off_o[2]}, 3'b010);
    chk(t_n - n0 == 5, "R5", "d2 save count", t_n - n0, 5);
    n0 = t_n;
    issue(2, 1'b0);
    wait_done("R7", 10, e, took);
    chk(t_n == n0 && took <= 3, "R7", "d2 already off via idle status", took, 3);
    issue(2, 1'b1);
    wait_done("R5", 200, e, took);
    chk(!e && !idle_req_o[2] && t_n - n0 == 5, "R5", "d2 back on",
        {e, idle_req_o[2], 8'(t_n - n0)}, 5);
  endtask

  task automatic t_timeout;
    bit e; int took;
    wrong_ack = 1'b1;
    issue(3, 1'b0);
    wait_done("R6", 300, e, took);
    chk(e, "R6", "timeout flagged", e, 1);
    chk(took >= TMO && took <= TMO + 40, "R6", "timeout latency", took, TMO);
    chk(!pwr_off_o[3], "R8", "ack on wrong bit not accepted", pwr_off_o[3], 0);
    wrong_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_off_d0();
    t_on_d0();
    t_already();
    t_no_handshake();
    t_idle_only();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule